// File: doc/BRIEF.md
# Link Trunk Port Selector

The selector sits in a switch's forwarding path, after the lookup that produces a candidate set of egress ports. When several physical ports are bundled into one logical trunk, a frame must leave by exactly one member of that trunk, and it must never be sent back into the trunk it arrived on. For every frame the block takes the candidate port vector, a hash key already computed from the frame's addresses, and the trunk group of the ingress port. It returns a pruned vector one clock later.

Load sharing is table driven. Software programs one port mask per hash key. In each mask exactly one member of every trunk group has its bit set. Ports that are not trunk members ignore the mask and pass straight through. Members of the ingress port's own group are always removed. A second table, indexed by trunk group and hash key, gives the device and port that own a given hash bucket. A side port reads this table combinationally. All tables and the per-port trunk settings are written and read back through one address/data port.

Top module: `trunk_port_select`

## Requirements
- R1: After reset, out_valid and out_fwd are 0. Every hash mask reads back all ones. Every map entry and every per-port setting reads back 0, so trunking is off on all ports.
- R2: out_valid equals in_valid delayed by one clock. out_fwd is 0 in every cycle where out_valid is 0.
- R3: On a port whose trunk enable is 0, the out_fwd bit equals the in_fwd bit of the previous cycle, whatever the hash mask holds.
- R4: On a port whose trunk enable is 1 that is not pruned, the out_fwd bit equals the in_fwd bit AND bit p of the mask selected by in_hash.
- R5: When in_src_trunk is 1, every port whose trunk enable is 1 and whose group equals in_src_grp is 0 in out_fwd. When in_src_trunk is 0, nothing is pruned.
- R6: out_fwd never has a bit set that was clear in the in_fwd it was computed from.
- R7: lk_dev and lk_port combinationally return the map entry at index {lk_grp, lk_key}. Within an entry, data bit 4 is the device and bits 3:0 are the port.
- R8: cfg_addr[6:5] selects the region: 0 is the hash masks (index = hash key), 1 is the map table (index = {group, key}), 2 is the per-port settings, and 3 is reserved. In the per-port settings, data bit 2 is the trunk enable and bits 1:0 are the group. cfg_rdata shows the addressed entry combinationally. A write is visible from the next cycle. The reserved region ignores writes and reads 0.
- R9: A write whose index is past the end of its region (a mask index of 8 or more, a port index of NUM_PORTS or more) changes no entry. Such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 7 | Region (bits 6:5) and entry index (bits 4:0) |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the addressed entry |
| in_valid | input | 1 | Frame request valid |
| in_fwd | input | 16 | Candidate egress port vector |
| in_hash | input | 3 | Load-sharing hash key |
| in_src_grp | input | 2 | Trunk group of the ingress port |
| in_src_trunk | input | 1 | Ingress port is a trunk member |
| out_valid | output | 1 | Result valid |
| out_fwd | output | 16 | Pruned egress port vector |
| lk_grp | input | 2 | Map lookup group |
| lk_key | input | 3 | Map lookup hash key |
| lk_dev | output | 1 | Device owning the bucket |
| lk_port | output | 4 | Port owning the bucket |

## Verification
The clocked properties compare each result with the request and the per-port settings of the cycle before. They therefore assume the settings seen at that edge are the ones the frame used. The stimulus keeps to this by never writing a table in the cycle a request is presented. The properties also take in_fwd, in_hash and the group as known values whenever in_valid is high. The bench drives every request field to a defined value and holds the tables steady during each sweep over hash key, source group, source-trunk flag and port pattern.

// File: rtl/tps_pkg.sv
package tps_pkg;

   localparam int unsigned MAP_DEV_W = 1;
   localparam int unsigned MAP_PID_W = 4;
   localparam int unsigned MAP_ENT_W = MAP_DEV_W + MAP_PID_W;

   typedef enum logic [1:0] {
      RGN_MASK = 2'd0,
      RGN_MAP  = 2'd1,
      RGN_PCFG = 2'd2,
      RGN_RSVD = 2'd3
   } rgn_e;

   typedef struct packed {
      logic [MAP_DEV_W-1:0] dev;
      logic [MAP_PID_W-1:0] port;
   } map_ent_t;

endpackage

// File: rtl/tps_mask_table.sv
module tps_mask_table #(
   parameter int unsigned NUM_PORTS = 16,
   parameter int unsigned HASH_W    = 3,
   parameter int unsigned IDX_W     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [NUM_PORTS-1:0] wr_data,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [NUM_PORTS-1:0] rd_data,
   input  logic [HASH_W-1:0]    key,
   output logic [NUM_PORTS-1:0] key_mask
);
   localparam int unsigned DEPTH = 1 << HASH_W;

   logic [NUM_PORTS-1:0] ent_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q[e] <= '1;
         end else if (wr_en && int'(wr_idx) == e) begin
            ent_q[e] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (int'(rd_idx) == e) rd_data = ent_q[e];
      end
   end

   assign key_mask = ent_q[key];

endmodule

// File: rtl/tps_map_table.sv
module tps_map_table
   import tps_pkg::*;
#(
   parameter int unsigned GRP_W  = 2,
   parameter int unsigned HASH_W = 3,
   parameter int unsigned IDX_W  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  map_ent_t                wr_ent,
   input  logic [IDX_W-1:0]        rd_idx,
   output map_ent_t                rd_ent,
   input  logic [GRP_W+HASH_W-1:0] lk_idx,
   output map_ent_t                lk_ent
);
   localparam int unsigned DEPTH = 1 << (GRP_W + HASH_W);

   map_ent_t ent_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q[e] <= '0;
         end else if (wr_en && int'(wr_idx) == e) begin
            ent_q[e] <= wr_ent;
         end
      end
   end

   always_comb begin
      rd_ent = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (int'(rd_idx) == e) rd_ent = ent_q[e];
      end
   end

   assign lk_ent = ent_q[lk_idx];

endmodule

// File: rtl/tps_port_cfg.sv
module tps_port_cfg #(
   parameter int unsigned NUM_PORTS = 16,
   parameter int unsigned GRP_W     = 2,
   parameter int unsigned IDX_W     = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic                       wr_trunk,
   input  logic [GRP_W-1:0]           wr_grp,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic                       rd_trunk,
   output logic [GRP_W-1:0]           rd_grp,
   output logic [NUM_PORTS-1:0]       trunk_en,
   output logic [NUM_PORTS*GRP_W-1:0] grp_flat
);
   logic [GRP_W-1:0] grp_q [NUM_PORTS];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            trunk_en[p] <= 1'b0;
            grp_q[p]    <= '0;
         end else if (wr_en && int'(wr_idx) == p) begin
            trunk_en[p] <= wr_trunk;
            grp_q[p]    <= wr_grp;
         end
      end
      assign grp_flat[p*GRP_W +: GRP_W] = grp_q[p];
   end

   always_comb begin
      rd_trunk = 1'b0;
      rd_grp   = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (int'(rd_idx) == p) begin
            rd_trunk = trunk_en[p];
            rd_grp   = grp_q[p];
         end
      end
   end

endmodule

// File: rtl/tps_select_core.sv
module tps_select_core #(
   parameter int unsigned NUM_PORTS = 16,
   parameter int unsigned GRP_W     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [NUM_PORTS-1:0]       req_fwd,
   input  logic [GRP_W-1:0]           req_src_grp,
   input  logic                       req_src_trunk,
   input  logic [NUM_PORTS-1:0]       key_mask,
   input  logic [NUM_PORTS-1:0]       trunk_en,
   input  logic [NUM_PORTS*GRP_W-1:0] grp_flat,
   output logic                       res_valid,
   output logic [NUM_PORTS-1:0]       res_fwd
);
   logic [NUM_PORTS-1:0] keep;
   logic [NUM_PORTS-1:0] prune;
   logic [NUM_PORTS-1:0] next_fwd;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bit
      assign keep[p]  = ~trunk_en[p] | key_mask[p];
      assign prune[p] = req_src_trunk & trunk_en[p] &
                        (grp_flat[p*GRP_W +: GRP_W] == req_src_grp);
   end

   assign next_fwd = req_fwd & keep & ~prune;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_fwd   <= '0;
      end else begin
         res_valid <= req_valid;
         res_fwd   <= req_valid ? next_fwd : '0;
      end
   end

endmodule

// File: rtl/trunk_port_select.sv
module trunk_port_select
   import tps_pkg::*;
#(
   parameter int unsigned NUM_PORTS  = 16,
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned HASH_W     = 3,
   localparam int unsigned GRP_W     = $clog2(NUM_GROUPS),
   localparam int unsigned PORT_AW   = $clog2(NUM_PORTS),
   localparam int unsigned MAP_AW    = GRP_W + HASH_W,
   localparam int unsigned IDX_W     = (MAP_AW > PORT_AW) ? MAP_AW : PORT_AW,
   localparam int unsigned ADDR_W    = IDX_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic [NUM_PORTS-1:0] cfg_wdata,
   output logic [NUM_PORTS-1:0] cfg_rdata,
   input  logic                 in_valid,
   input  logic [NUM_PORTS-1:0] in_fwd,
   input  logic [HASH_W-1:0]    in_hash,
   input  logic [GRP_W-1:0]     in_src_grp,
   input  logic                 in_src_trunk,
   output logic                 out_valid,
   output logic [NUM_PORTS-1:0] out_fwd,
   input  logic [GRP_W-1:0]     lk_grp,
   input  logic [HASH_W-1:0]    lk_key,
   output logic [MAP_DEV_W-1:0] lk_dev,
   output logic [MAP_PID_W-1:0] lk_port
);
   // elaboration-time parameter checks
   if (NUM_GROUPS < 2 || (1 << GRP_W) != NUM_GROUPS) begin : g_bad_groups
      $error("NUM_GROUPS must be a power of two, at least 2");
   end
   if (HASH_W < 1 || HASH_W > 6) begin : g_bad_hash
      $error("HASH_W must lie in 1..6");
   end
   if (NUM_PORTS < MAP_ENT_W || NUM_PORTS < GRP_W + 1 || NUM_PORTS > 64) begin : g_bad_ports
      $error("NUM_PORTS too small to carry a table entry or above 64");
   end

   rgn_e             rgn;
   logic [IDX_W-1:0] idx;

   assign rgn = rgn_e'(cfg_addr[ADDR_W-1 -: 2]);
   assign idx = cfg_addr[IDX_W-1:0];

   logic                       we_mask, we_map, we_pcfg;
   logic [NUM_PORTS-1:0]       mask_rd, key_mask;
   map_ent_t                   map_rd, map_wr, map_lk;
   logic                       pcfg_rd_trunk;
   logic [GRP_W-1:0]           pcfg_rd_grp;
   logic [NUM_PORTS-1:0]       port_trunk_en;
   logic [NUM_PORTS*GRP_W-1:0] port_grp_flat;

   assign we_mask = cfg_we && (rgn == RGN_MASK);
   assign we_map  = cfg_we && (rgn == RGN_MAP);
   assign we_pcfg = cfg_we && (rgn == RGN_PCFG);
   assign map_wr  = map_ent_t'(cfg_wdata[MAP_ENT_W-1:0]);

   tps_mask_table #(
      .NUM_PORTS (NUM_PORTS),
      .HASH_W    (HASH_W),
      .IDX_W     (IDX_W)
   ) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (we_mask),
      .wr_idx   (idx),
      .wr_data  (cfg_wdata),
      .rd_idx   (idx),
      .rd_data  (mask_rd),
      .key      (in_hash),
      .key_mask (key_mask)
   );

   tps_map_table #(
      .GRP_W  (GRP_W),
      .HASH_W (HASH_W),
      .IDX_W  (IDX_W)
   ) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (we_map),
      .wr_idx (idx),
      .wr_ent (map_wr),
      .rd_idx (idx),
      .rd_ent (map_rd),
      .lk_idx ({lk_grp, lk_key}),
      .lk_ent (map_lk)
   );

   tps_port_cfg #(
      .NUM_PORTS (NUM_PORTS),
      .GRP_W     (GRP_W),
      .IDX_W     (IDX_W)
   ) u_pcfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (we_pcfg),
      .wr_idx   (idx),
      .wr_trunk (cfg_wdata[GRP_W]),
      .wr_grp   (cfg_wdata[GRP_W-1:0]),
      .rd_idx   (idx),
      .rd_trunk (pcfg_rd_trunk),
      .rd_grp   (pcfg_rd_grp),
      .trunk_en (port_trunk_en),
      .grp_flat (port_grp_flat)
   );

   tps_select_core #(
      .NUM_PORTS (NUM_PORTS),
      .GRP_W     (GRP_W)
   ) u_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (in_valid),
      .req_fwd       (in_fwd),
      .req_src_grp   (in_src_grp),
      .req_src_trunk (in_src_trunk),
      .key_mask      (key_mask),
      .trunk_en      (port_trunk_en),
      .grp_flat      (port_grp_flat),
      .res_valid     (out_valid),
      .res_fwd       (out_fwd)
   );

   always_comb begin
      cfg_rdata = '0;
      unique case (rgn)
         RGN_MASK: cfg_rdata = mask_rd;
         RGN_MAP:  cfg_rdata[MAP_ENT_W-1:0] = map_rd;
         RGN_PCFG: cfg_rdata[GRP_W:0] = {pcfg_rd_trunk, pcfg_rd_grp};
         RGN_RSVD: cfg_rdata = '0;
      endcase
   end

   assign lk_dev  = map_lk.dev;
   assign lk_port = map_lk.port;

endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
   parameter int unsigned NUM_PORTS = 16,
   parameter int unsigned GRP_W     = 2,
   parameter int unsigned ADDR_W    = 7
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          cfg_addr,
   input logic [NUM_PORTS-1:0]       cfg_rdata,
   input logic                       in_valid,
   input logic [NUM_PORTS-1:0]       in_fwd,
   input logic [GRP_W-1:0]           in_src_grp,
   input logic                       in_src_trunk,
   input logic                       out_valid,
   input logic [NUM_PORTS-1:0]       out_fwd,
   input logic [NUM_PORTS-1:0]       port_trunk_en,
   input logic [NUM_PORTS*GRP_W-1:0] port_grp_flat
);
   logic [NUM_PORTS-1:0] same_grp;

   always_comb begin
      for (int p = 0; p < NUM_PORTS; p++) begin
         same_grp[p] = port_trunk_en[p] &&
                       (port_grp_flat[p*GRP_W +: GRP_W] == in_src_grp);
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                                   // R2
   AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                                 // R2
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_fwd == '0);                                             // R2
   AST_NO_NEW_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_fwd & ~$past(in_fwd)) == '0);                            // R6
   AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((out_fwd ^ $past(in_fwd)) & ~$past(port_trunk_en)) == '0);   // R3
   AST_SRC_GROUP_PRUNED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_src_trunk) |=> (out_fwd & $past(same_grp)) == '0);         // R5
   AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_addr[ADDR_W-1 -: 2] == 2'd3 |-> cfg_rdata == '0);                      // R8

endmodule

bind trunk_port_select tps_checker #(
   .NUM_PORTS (NUM_PORTS),
   .GRP_W     (GRP_W),
   .ADDR_W    (ADDR_W)
) u_tps_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_addr      (cfg_addr),
   .cfg_rdata     (cfg_rdata),
   .in_valid      (in_valid),
   .in_fwd        (in_fwd),
   .in_src_grp    (in_src_grp),
   .in_src_trunk  (in_src_trunk),
   .out_valid     (out_valid),
   .out_fwd       (out_fwd),
   .port_trunk_en (port_trunk_en),
   .port_grp_flat (port_grp_flat)
);

// File: tb/trunk_port_select_test.sv
module trunk_port_select_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        in_valid = 1'b0;
   logic [15:0] in_fwd = '0;
   logic [2:0]  in_hash = '0;
   logic [1:0]  in_src_grp = '0;
   logic        in_src_trunk = 1'b0;
   logic        out_valid;
   logic [15:0] out_fwd;
   logic [1:0]  lk_grp = '0;
   logic [2:0]  lk_key = '0;
   logic        lk_dev;
   logic [3:0]  lk_port;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   trunk_port_select uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
      .in_fwd(in_fwd), .in_hash(in_hash), .in_src_grp(in_src_grp),
      .in_src_trunk(in_src_trunk), .out_valid(out_valid), .out_fwd(out_fwd),
      .lk_grp(lk_grp), .lk_key(lk_key), .lk_dev(lk_dev), .lk_port(lk_port)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] rg, input int idx, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {rg, 5'(idx)}; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] rg, input int idx, input logic [15:0] exp,
                         input string req);
      @(negedge clk);
      cfg_addr = {rg, 5'(idx)};
      #1;
      chk(cfg_rdata == exp, req, 32'(cfg_rdata), 32'(exp));
   endtask

   // bench model of the programmed configuration
   function automatic bit m_en(input int p);
      return p < 12;
   endfunction
   function automatic int m_grp(input int p);
      return p % 4;
   endfunction
   function automatic logic [15:0] m_mask(input int k);
      logic [15:0] m = '0;
      for (int p = 0; p < 16; p++) begin
         if (p < 12) m[p] = ((p / 4) == ((k + (p % 4)) % 3));
         else        m[p] = ((p + k) % 2) == 1;
      end
      return m;
   endfunction

   function automatic logic [15:0] pat(input int i);
      case (i)
         0: return 16'hFFFF;
         1: return 16'h0000;
         2: return 16'hA5A5;
         3: return 16'h5A5A;
         4: return 16'h0F0F;
         default: return 16'h1234;
      endcase
   endfunction

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] dis_m;
      dis_m = 16'hF000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
      chk(out_fwd == 16'h0, "R1 out_fwd", 32'(out_fwd), 0);
      for (int k = 0; k < 8; k++) rd_chk(2'd0, k, 16'hFFFF, "R1 mask reset");
      rd_chk(2'd1, 9, 16'h0, "R1 map reset");
      rd_chk(2'd2, 5, 16'h0, "R1 port cfg reset");
      #1;
      chk({lk_dev, lk_port} == 5'h0, "R1 lookup reset", 32'({lk_dev, lk_port}), 0);

      // R3 with trunking off everywhere, mask all ones: output equals input
      @(negedge clk);
      in_valid = 1'b1; in_fwd = 16'hC3A5; in_hash = 3'd2;
      in_src_trunk = 1'b1; in_src_grp = 2'd0;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_fwd == 16'hC3A5, "R3 untrunked pass", 32'(out_fwd), 32'h0000C3A5);

      // program configuration (R8 data layout)
      for (int p = 0; p < 16; p++)
         wr(2'd2, p, m_en(p) ? 16'(4 + m_grp(p)) : 16'(m_grp(p)));
      for (int k = 0; k < 8; k++) wr(2'd0, k, m_mask(k));
      for (int i = 0; i < 32; i++) wr(2'd1, i, 16'((i * 7 + 3) % 32));

      // R8 readback of every region
      for (int k = 0; k < 8; k++) rd_chk(2'd0, k, m_mask(k), "R8 mask readback");
      for (int p = 0; p < 16; p++)
         rd_chk(2'd2, p, m_en(p) ? 16'(4 + m_grp(p)) : 16'(m_grp(p)), "R8 port cfg readback");
      for (int i = 0; i < 32; i++) rd_chk(2'd1, i, 16'((i * 7 + 3) % 32), "R8 map readback");

      // R7 lookup sweep
      for (int g = 0; g < 4; g++) begin
         for (int k = 0; k < 8; k++) begin
            logic [4:0] e;
            e = 5'(((g * 8 + k) * 7 + 3) % 32);
            @(negedge clk);
            lk_grp = 2'(g); lk_key = 3'(k);
            #1;
            chk(lk_dev == e[4], "R7 lookup dev", 32'(lk_dev), 32'(e[4]));
            chk(lk_port == e[3:0], "R7 lookup port", 32'(lk_port), 32'(e[3:0]));
         end
      end

      // R3 R4 R5 R6 sweep
      for (int k = 0; k < 8; k++) begin
         for (int sg = 0; sg < 4; sg++) begin
            for (int st = 0; st < 2; st++) begin
               for (int pi = 0; pi < 6; pi++) begin
                  logic [15:0] f, keepm, prunem, exp;
                  f = pat(pi);
                  keepm = '0; prunem = '0;
                  for (int p = 0; p < 16; p++) begin
                     keepm[p]  = !m_en(p) || m_mask(k)[p];
                     prunem[p] = (st == 1) && m_en(p) && (m_grp(p) == sg);
                  end
                  exp = f & keepm & ~prunem;
                  @(negedge clk);
                  in_valid = 1'b1; in_fwd = f; in_hash = 3'(k);
                  in_src_grp = 2'(sg); in_src_trunk = 1'(st);
                  @(negedge clk);
                  in_valid = 1'b0;
                  chk(out_valid == 1'b1, "R2 valid after request", 32'(out_valid), 1);
                  chk((out_fwd & dis_m) == (f & dis_m), "R3 disabled ports pass",
                      32'(out_fwd & dis_m), 32'(f & dis_m));
                  chk((out_fwd & ~dis_m & ~prunem) == (exp & ~dis_m & ~prunem),
                      "R4 masked members", 32'(out_fwd), 32'(exp));
                  chk((out_fwd & prunem) == 16'h0, "R5 source group pruned",
                      32'(out_fwd & prunem), 0);
                  chk((out_fwd & ~f) == 16'h0, "R6 subset", 32'(out_fwd), 32'(f));
               end
            end
         end
      end

      // R2 back-to-back then idle
      @(negedge clk);
      in_valid = 1'b1; in_fwd = 16'hF000; in_src_trunk = 1'b0;
      @(negedge clk);
      in_fwd = 16'hE000;
      chk(out_valid && out_fwd == 16'hF000, "R2 first of pair", 32'(out_fwd), 32'h0000F000);
      @(negedge clk);
      in_valid = 1'b0; in_fwd = 16'hFFFF;
      chk(out_valid && out_fwd == 16'hE000, "R2 second of pair", 32'(out_fwd), 32'h0000E000);
      @(negedge clk);
      chk(!out_valid && out_fwd == 16'h0, "R2 idle clears", 32'({out_valid, out_fwd}), 0);

      // R8 reserved region
      wr(2'd3, 1, 16'hFFFF);
      rd_chk(2'd3, 1, 16'h0, "R8 reserved reads zero");

      // R9 out-of-range indices
      wr(2'd0, 8, 16'h0000);
      rd_chk(2'd0, 0, m_mask(0), "R9 mask index 8 ignored");
      rd_chk(2'd0, 8, 16'h0, "R9 mask index 8 reads zero");
      wr(2'd2, 20, 16'h0007);
      rd_chk(2'd2, 4, 16'(4 + m_grp(4)), "R9 port index 20 ignored");
      rd_chk(2'd2, 20, 16'h0, "R9 port index 20 reads zero");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule